// File: doc/BRIEF.md
# Prioritized Seven-Channel DMA Arbiter

This block decides which channel of a seven-channel DMA controller owns the single bus master for its next transfer. Each channel's request comes from a group of peripheral request lines that are ORed together. A channel that is enabled and set up for memory-to-memory copying requests all the time, with no peripheral trigger. A channel that is disabled never requests.

Each channel carries a two-bit software priority. A higher level always wins. The channel number only settles ties, and the lower-numbered channel wins a tie. The winner is captured in a registered one-hot grant. That grant stays put until the transfer engine acknowledges the single transfer. On the acknowledge cycle the arbiter runs again, so the next grant can follow on the very next cycle.

Top module: `dma_chan_arbiter`

## Requirements
- R1: A channel requests only when its enable bit is 1 and either its memory-to-memory bit is 1 or at least one of its 6 peripheral lines is 1. Line k of channel c is bit c*6+k of `periph_req`. A disabled channel is never granted, whatever its lines show.
- R2: An enabled channel with its memory-to-memory bit set is granted even when all of its peripheral lines are 0.
- R3: The priority field of channel c is bits 2c+1:2c of `prio_lvl`, with 0 = low, 1 = medium, 2 = high and 3 = very high. A requesting channel with a higher level wins over any requesting channel with a lower level, whatever the channel numbers.
- R4: Among requesting channels that share the highest level, the lowest-numbered channel is granted.
- R5: `grant` has at most one bit set. While no grant is held and no channel requests, `grant` stays all zero.
- R6: While no grant is held, the winner computed from the inputs of one cycle appears on `grant` after the next rising clock edge.
- R7: A held grant does not change, whatever the requests, priorities or enables do, until a cycle with `xfer_ack` = 1.
- R8: In a cycle where a grant is held and `xfer_ack` is 1, arbitration runs on that cycle's inputs. The next cycle shows the new winner, or all zero if nothing requests. `xfer_ack` is ignored while no grant is held.
- R9: `grant_id` gives the binary number of the granted channel and is 0 when idle. `grant_busy` is 1 exactly when a bit of `grant` is set.
- R10: While `rst_n` is low, `grant` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 7 | Per-channel enable |
| mem2mem | input | 7 | Per-channel memory-to-memory mode (continuous request) |
| periph_req | input | 42 | Peripheral request lines, 6 per channel |
| prio_lvl | input | 14 | Two-bit software priority per channel |
| xfer_ack | input | 1 | Engine acknowledges the granted single transfer |
| grant | output | 7 | One-hot grant to the winning channel |
| grant_id | output | 3 | Binary number of the granted channel |
| grant_busy | output | 1 | A grant is held |

## Verification
A corrupted grant register shows up on the ports within one cycle. It appears as a grant with more than one bit set, or as a grant that moves without an acknowledge, or as a grant that stays up after an acknowledge when a different winner was due. A wrong priority comparison or tie-break becomes visible on the first cycle after an idle or acknowledge cycle in which two requesting channels differ in level or in number. The random phase is built to create that situation often. A mistake in the request combining shows up as a grant to a disabled channel, or as a missing grant for a memory-to-memory channel that has no line active, one edge after the inputs are applied.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    // software priority width and encoding
    localparam int PRIO_W = 2;
    typedef enum logic [PRIO_W-1:0] {
        PRIO_LOW   = 2'd0,
        PRIO_MED   = 2'd1,
        PRIO_HIGH  = 2'd2,
        PRIO_VHIGH = 2'd3
    } prio_e;
endpackage

// File: rtl/arb_req_combine.sv
module arb_req_combine #(
    parameter int NUM_CH = 7,
    parameter int LINES  = 6
) (
    input  logic [NUM_CH-1:0]       chan_en,
    input  logic [NUM_CH-1:0]       mem2mem,
    input  logic [NUM_CH*LINES-1:0] lines,
    output logic [NUM_CH-1:0]       req
);
    // one OR group per channel, gated by enable
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign req[c] = chan_en[c] & (mem2mem[c] | (|lines[c*LINES +: LINES]));
    end
endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        req,
    input  logic [NUM_CH*PRIO_W-1:0] prio,
    output logic [NUM_CH-1:0]        win,
    output logic [PRIO_W-1:0]        win_prio
);
    logic found;

    // ascending scan with strict compare: ties keep the lower number
    always_comb begin
        win      = '0;
        win_prio = '0;
        found    = 1'b0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (req[c] && (!found || prio[c*PRIO_W +: PRIO_W] > win_prio)) begin
                win      = '0;
                win[c]   = 1'b1;
                win_prio = prio[c*PRIO_W +: PRIO_W];
                found    = 1'b1;
            end
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R3
        win_not_outranked_chk: assert property (@(posedge clk) disable iff (!rst_n)
            req[c] |-> prio[c*PRIO_W +: PRIO_W] <= win_prio);
    end

    // R5
    win_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win));
endmodule

// File: rtl/arb_grant_reg.sv
module arb_grant_reg #(
    parameter int NUM_CH = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] win,
    input  logic              ack,
    output logic [NUM_CH-1:0] grant
);
    typedef struct packed {
        logic [NUM_CH-1:0] grant;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.grant == '0 || ack) begin
            st_d.grant = win;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant = st_q.grant;

    // R7
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.grant != '0 && !ack) |=> $stable(st_q.grant));

    // R5
    idle_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.grant == '0 && win == '0) |=> st_q.grant == '0);

    // R5
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.grant));
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int LINES  = 6,
    localparam int ID_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        chan_en,
    input  logic [NUM_CH-1:0]        mem2mem,
    input  logic [NUM_CH*LINES-1:0]  periph_req,
    input  logic [NUM_CH*PRIO_W-1:0] prio_lvl,
    input  logic                     xfer_ack,
    output logic [NUM_CH-1:0]        grant,
    output logic [ID_W-1:0]          grant_id,
    output logic                     grant_busy
);
    logic [NUM_CH-1:0] req_vec;
    logic [NUM_CH-1:0] win_vec;
    logic [PRIO_W-1:0] win_prio;

    arb_req_combine #(.NUM_CH(NUM_CH), .LINES(LINES)) u_comb (
        .chan_en (chan_en),
        .mem2mem (mem2mem),
        .lines   (periph_req),
        .req     (req_vec)
    );

    arb_prio_pick #(.NUM_CH(NUM_CH)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req_vec),
        .prio     (prio_lvl),
        .win      (win_vec),
        .win_prio (win_prio)
    );

    arb_grant_reg #(.NUM_CH(NUM_CH)) u_greg (
        .clk   (clk),
        .rst_n (rst_n),
        .win   (win_vec),
        .ack   (xfer_ack),
        .grant (grant)
    );

    always_comb begin
        grant_id = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (grant[c]) grant_id = ID_W'(c);
        end
    end

    assign grant_busy = |grant;

    // R1
    granted_was_requesting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 || xfer_ack) |=> ((grant & $past(req_vec)) == grant));

    // R9
    id_matches_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_busy |-> grant[grant_id]);
endmodule

// File: tb/dma_chan_arbiter_test.sv
module dma_chan_arbiter_test;
    localparam int NCH = 7;
    localparam int NL  = 6;
    localparam time TCK = 20ns;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  chan_en = '0;
    logic [NCH-1:0]  mem2mem = '0;
    logic [NCH*NL-1:0] periph_req = '0;
    logic [NCH*2-1:0] prio_lvl = '0;
    logic            xfer_ack = 1'b0;
    logic [NCH-1:0]  grant;
    logic [2:0]      grant_id;
    logic            grant_busy;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;
    logic [NCH-1:0] exp_g = '0;

    always #(TCK/2) clk = ~clk;

    dma_chan_arbiter uut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .mem2mem(mem2mem),
        .periph_req(periph_req), .prio_lvl(prio_lvl), .xfer_ack(xfer_ack),
        .grant(grant), .grant_id(grant_id), .grant_busy(grant_busy)
    );

    function automatic logic [NCH-1:0] model_win();
        logic [NCH-1:0] w = '0;
        int bp = -1;
        for (int c = 0; c < NCH; c++) begin
            logic r;
            r = chan_en[c] & (mem2mem[c] | (|periph_req[c*NL +: NL]));
            if (r && int'(prio_lvl[c*2 +: 2]) > bp) begin
                w = '0; w[c] = 1'b1; bp = int'(prio_lvl[c*2 +: 2]);
            end
        end
        return w;
    endfunction

    function automatic logic [2:0] model_id(input logic [NCH-1:0] g);
        logic [2:0] id = '0;
        for (int c = 0; c < NCH; c++) if (g[c]) id = 3'(c);
        return id;
    endfunction

    task automatic check_outs(input string tag);
        vectors++;
        if (grant !== exp_g || grant_id !== model_id(exp_g) || grant_busy !== (|exp_g)) begin
            misses++;
            $display("FAIL %s: grant=%b id=%0d busy=%b expected grant=%b id=%0d busy=%b",
                     tag, grant, grant_id, grant_busy, exp_g, model_id(exp_g), |exp_g);
        end
    endtask

    // inputs are set at the negedge before calling; one clock, then check
    task automatic step(input logic ack, input string tag);
        xfer_ack = ack;
        @(posedge clk);
        #1;
        if (exp_g == '0 || ack) exp_g = model_win();
        @(negedge clk);
        check_outs(tag);
    endtask

    task automatic clear_inputs();
        chan_en = '0; mem2mem = '0; periph_req = '0; prio_lvl = '0;
    endtask

    // finish outstanding grant and return to idle
    task automatic drain();
        clear_inputs();
        step(1'b1, "R8 drain");
        step(1'b0, "R5 idle");
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240601);
        repeat (3) @(negedge clk);
        exp_g = '0;
        check_outs("R10 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_outs("R10 after reset");

        // R1: lines of channel 4 asserted but channel disabled
        periph_req[4*NL + 2] = 1'b1;
        step(1'b0, "R1 disabled ignored");
        // R1: enable it; single line raises request
        chan_en[4] = 1'b1;
        step(1'b0, "R1 single line");
        if (grant !== 7'b0010000) begin misses++; $display("FAIL R1: grant=%b expected 0010000", grant); end
        vectors++;
        drain();

        // R2: memory-to-memory with no lines
        chan_en[6] = 1'b1; mem2mem[6] = 1'b1;
        step(1'b0, "R2 m2m request");
        drain();

        // R3: high number with very high priority beats channel 0
        chan_en = 7'h7F; periph_req[0] = 1'b1; periph_req[5*NL+5] = 1'b1;
        prio_lvl[5*2 +: 2] = 2'd3; prio_lvl[0 +: 2] = 2'd2;
        step(1'b0, "R3 priority override");
        if (grant_id !== 3'd5) begin misses++; $display("FAIL R3: id=%0d expected 5", grant_id); end
        vectors++;
        drain();

        // R4: tie between channels 1 and 3
        chan_en = 7'h7F; periph_req[1*NL] = 1'b1; periph_req[3*NL+4] = 1'b1;
        prio_lvl[1*2 +: 2] = 2'd1; prio_lvl[3*2 +: 2] = 2'd1;
        step(1'b0, "R4 tie");
        if (grant !== 7'b0000010) begin misses++; $display("FAIL R4: grant=%b expected 0000010", grant); end
        vectors++;
        // R7: raise a stronger request while held, no ack
        prio_lvl[3*2 +: 2] = 2'd3;
        step(1'b0, "R7 held");
        chan_en[1] = 1'b0;
        step(1'b0, "R7 held after disable");
        // R8: ack re-arbitrates to channel 3
        step(1'b1, "R8 rearbitrate");
        if (grant_id !== 3'd3) begin misses++; $display("FAIL R8: id=%0d expected 3", grant_id); end
        vectors++;
        drain();

        // R8: ack while idle is ignored
        step(1'b1, "R8 ack idle");
        // R9: id of channel 0 grant
        chan_en[0] = 1'b1; mem2mem[0] = 1'b1;
        step(1'b0, "R9 id zero busy");
        drain();

        // random phase
        for (int i = 0; i < 3000; i++) begin
            chan_en    = 7'($urandom);
            mem2mem    = 7'($urandom) & 7'($urandom) & 7'($urandom);
            periph_req = {10'($urandom), 32'($urandom)} & {10'($urandom), 32'($urandom)}
                         & {10'($urandom), 32'($urandom)};
            prio_lvl   = 14'($urandom);
            step(1'($urandom % 3 == 0), "R6/R7/R8 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule